// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block decides when an asynchronous page-mode DRAM needs a CAS-before-RAS refresh and passes that to the access sequencer as a request/grant handshake. The sequencer drives the strobes itself. The device keeps its own internal row counter, so this block only counts how many refresh slots are owed. After reset the block waits for a power-up delay. It then asks for a burst of wake-up refreshes and only after that allows normal accesses. In normal operation one slot becomes due every fixed interval. Unserved slots pile up as a backlog. An urgent flag tells the sequencer to close its open page, and a backlog that reaches the overdue limit restarts the wake-up burst.

On a sleep request, with nothing owed, the block commands self refresh. It holds that command for a minimum time, then gives a fixed precharge gap after the exit request. After the gap it either returns straight to distributed refresh or first asks for a refresh of every row back to back, as selected by an input. All delays are parameters counted in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: While reset is applied and just after it, refReq, accessOk, selfCmd and urgent are low and backlog is zero.
- R2: refReq rises exactly WAKE_WAIT clock edges after reset is released, with backlog equal to WAKE_COUNT.
- R3: An edge where refGrant and refReq are both high lowers backlog by exactly one. A grant while refReq is low is ignored.
- R4: accessOk stays low until every wake-up slot has been granted. It rises one edge after backlog reaches zero.
- R5: While accessOk is high, one slot is added every SLOT_CYCLES edges, the first one SLOT_CYCLES edges after accessOk rises. An edge that adds a slot and takes a grant leaves backlog unchanged.
- R6: urgent is high exactly when backlog is greater than URGENT_LEVEL.
- R7: When backlog reaches OVERDUE_LIMIT in normal operation, at the next edge accessOk falls and backlog is reloaded with WAKE_COUNT, so the wake-up burst runs again.
- R8: Self refresh is entered only from normal operation, with sleepReq high and backlog zero. selfCmd rises at the edge after that condition holds, and accessOk is low while selfCmd is high.
- R9: selfCmd stays high for at least SELF_MIN edges, however early sleepExit arrives, and no slots are added while it is high.
- R10: After selfCmd falls, refReq and accessOk stay low for EXIT_PRE edges.
- R11: If burstOnExit is low at the end of the precharge gap, accessOk resumes with backlog zero. If it is high, backlog is loaded with ROWS and accessOk returns only after all of them are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refGrant | input | 1 | Sequencer has issued one refresh cycle |
| sleepReq | input | 1 | Ask to enter self refresh |
| sleepExit | input | 1 | Ask to leave self refresh |
| burstOnExit | input | 1 | After self refresh, refresh every row before resuming |
| refReq | output | 1 | One or more refresh slots are owed |
| selfCmd | output | 1 | Sequencer should hold the device in self refresh |
| accessOk | output | 1 | Normal reads and writes are allowed |
| urgent | output | 1 | Backlog is above the urgent level |
| backlog | output | CNT_W | Number of owed refresh slots |

## Verification
Every output comes straight from a register. A grant, a sleep request or a phase timeout seen at one edge therefore shows up on the ports just after that edge, and state changes that wait for backlog to reach zero show one edge later. The bench counts edges from reset or from the last stimulus edge. It samples a quarter period after each edge and changes its inputs at the same point, so each expected value is tied to an exact edge number. Slot arrival, urgent and overdue points are all computed as multiples of SLOT_CYCLES. The wake-up, self-refresh minimum and precharge windows are swept edge by edge on both sides of their limits.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_WAKE  = 3'd1,
    PH_RUN   = 3'd2,
    PH_SELF  = 3'd3,
    PH_EXIT  = 3'd4,
    PH_BURST = 3'd5
  } phase_e;

  typedef struct packed {
    logic reqEn;
    logic ldWake;
    logic ldBurst;
    logic slotEn;
    logic phaseClr;
  } ctlStrobe_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int WAKE_COUNT    = 8,
  parameter int ROWS          = 4096,
  parameter int SLOT_CYCLES   = 781,
  parameter int OVERDUE_LIMIT = 4096,
  parameter int CNT_W         = 13,
  parameter int PH_W          = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             refGrant,
  output logic [CNT_W-1:0] pending,
  output logic             pendingZero,
  output logic             overdue,
  output logic [PH_W-1:0]  phaseCnt
);

  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [SLOT_W-1:0] slotCnt;
  logic              tick;
  logic              take;

  assign pendingZero = (pending == '0);
  assign overdue     = (pending >= CNT_W'(OVERDUE_LIMIT));
  assign tick        = ctl.slotEn && (slotCnt == SLOT_W'(SLOT_CYCLES - 1));
  assign take        = ctl.reqEn && refGrant && !pendingZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (!ctl.slotEn || tick) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (ctl.ldWake) begin
      pending <= CNT_W'(WAKE_COUNT);
    end else if (ctl.ldBurst) begin
      pending <= CNT_W'(ROWS);
    end else if (tick && !take) begin
      pending <= pending + CNT_W'(1);
    end else if (take && !tick) begin
      pending <= pending - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.phaseClr) begin
      phaseCnt <= '0;
    end else if (phaseCnt != '1) begin
      phaseCnt <= phaseCnt + PH_W'(1);
    end
  end

endmodule

// File: rtl/refsched_ctl.sv
module refsched_ctl
  import refsched_pkg::*;
#(
  parameter int WAKE_WAIT = 5000,
  parameter int SELF_MIN  = 5000,
  parameter int EXIT_PRE  = 6,
  parameter int PH_W      = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sleepReq,
  input  logic            sleepExit,
  input  logic            burstOnExit,
  input  logic            pendingZero,
  input  logic            overdue,
  input  logic [PH_W-1:0] phaseCnt,
  output ctlStrobe_t      ctl,
  output logic            accessOk,
  output logic            selfCmd
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_WAIT:
        if (phaseCnt == PH_W'(WAKE_WAIT - 1)) phaseNext = PH_WAKE;
      PH_WAKE, PH_BURST:
        if (pendingZero) phaseNext = PH_RUN;
      PH_RUN:
        if (overdue)                       phaseNext = PH_WAKE;
        else if (sleepReq && pendingZero)  phaseNext = PH_SELF;
      PH_SELF:
        if (sleepExit && (phaseCnt >= PH_W'(SELF_MIN - 1))) phaseNext = PH_EXIT;
      PH_EXIT:
        if (phaseCnt == PH_W'(EXIT_PRE - 1))
          phaseNext = burstOnExit ? PH_BURST : PH_RUN;
      default: phaseNext = PH_WAIT;
    endcase
  end

  always_comb begin
    ctl.reqEn    = (phase == PH_WAKE) || (phase == PH_RUN) || (phase == PH_BURST);
    ctl.ldWake   = (phaseNext == PH_WAKE)  && (phase != PH_WAKE);
    ctl.ldBurst  = (phaseNext == PH_BURST) && (phase != PH_BURST);
    ctl.slotEn   = (phase == PH_RUN) && (phaseNext == PH_RUN);
    ctl.phaseClr = (phaseNext != phase);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WAIT;
    else       phase <= phaseNext;
  end

  assign accessOk = (phase == PH_RUN);
  assign selfCmd  = (phase == PH_SELF);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int WAKE_WAIT     = 5000,
  parameter int WAKE_COUNT    = 8,
  parameter int ROWS          = 4096,
  parameter int SLOT_CYCLES   = 781,
  parameter int SELF_MIN      = 5000,
  parameter int EXIT_PRE      = 6,
  parameter int URGENT_LEVEL  = 8,
  parameter int OVERDUE_LIMIT = 4096,
  localparam int MAX_A = (ROWS > OVERDUE_LIMIT) ? ROWS : OVERDUE_LIMIT,
  localparam int MAX_C = (MAX_A > WAKE_COUNT) ? MAX_A : WAKE_COUNT,
  localparam int CNT_W = $clog2(MAX_C + 1),
  localparam int MAX_P = (WAKE_WAIT > SELF_MIN) ? WAKE_WAIT : SELF_MIN,
  localparam int MAX_Q = (MAX_P > EXIT_PRE) ? MAX_P : EXIT_PRE,
  localparam int PH_W  = $clog2(MAX_Q + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGrant,
  input  logic             sleepReq,
  input  logic             sleepExit,
  input  logic             burstOnExit,
  output logic             refReq,
  output logic             selfCmd,
  output logic             accessOk,
  output logic             urgent,
  output logic [CNT_W-1:0] backlog
);

  ctlStrobe_t      ctl;
  logic            pendingZero;
  logic            overdue;
  logic [PH_W-1:0] phaseCnt;

  refsched_ctl #(
    .WAKE_WAIT(WAKE_WAIT), .SELF_MIN(SELF_MIN), .EXIT_PRE(EXIT_PRE), .PH_W(PH_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepExit(sleepExit),
    .burstOnExit(burstOnExit), .pendingZero(pendingZero), .overdue(overdue),
    .phaseCnt(phaseCnt), .ctl(ctl), .accessOk(accessOk), .selfCmd(selfCmd)
  );

  refsched_dp #(
    .WAKE_COUNT(WAKE_COUNT), .ROWS(ROWS), .SLOT_CYCLES(SLOT_CYCLES),
    .OVERDUE_LIMIT(OVERDUE_LIMIT), .CNT_W(CNT_W), .PH_W(PH_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refGrant(refGrant), .pending(backlog),
    .pendingZero(pendingZero), .overdue(overdue), .phaseCnt(phaseCnt)
  );

  assign refReq = ctl.reqEn && !pendingZero;
  assign urgent = (backlog > CNT_W'(URGENT_LEVEL));

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
  parameter int WAKE_COUNT = 8,
  parameter int SELF_MIN   = 5000,
  parameter int EXIT_PRE   = 6,
  parameter int CNT_W      = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             refReq,
  input logic             refGrant,
  input logic             selfCmd,
  input logic             accessOk,
  input logic [CNT_W-1:0] backlog
);

  logic [31:0] selfLen;
  logic [31:0] gapCnt;
  logic [31:0] grantsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selfLen    <= '0;
      gapCnt     <= '1;
      grantsSeen <= '0;
    end else begin
      selfLen <= selfCmd ? ((selfLen != '1) ? selfLen + 32'd1 : selfLen) : '0;
      gapCnt  <= selfCmd ? '0 : ((gapCnt != '1) ? gapCnt + 32'd1 : gapCnt);
      if (refReq && refGrant && (grantsSeen < 32'(WAKE_COUNT)))
        grantsSeen <= grantsSeen + 32'd1;
    end
  end

  // R4
  wake_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessOk |-> grantsSeen >= 32'(WAKE_COUNT));

  // R8
  sleep_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfCmd) |-> $past(backlog) == '0);

  // R8
  sleep_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(selfCmd && accessOk));

  // R9
  self_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfCmd) |-> selfLen >= 32'(SELF_MIN));

  // R10
  exit_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessOk || refReq) |-> gapCnt >= 32'(EXIT_PRE));

endmodule

bind refresh_sched refsched_chk #(
  .WAKE_COUNT(WAKE_COUNT), .SELF_MIN(SELF_MIN), .EXIT_PRE(EXIT_PRE), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .refReq(refReq), .refGrant(refGrant),
  .selfCmd(selfCmd), .accessOk(accessOk), .backlog(backlog)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;

  localparam int WW   = 10;
  localparam int WC   = 8;
  localparam int NR   = 16;
  localparam int SL   = 20;
  localparam int SMIN = 30;
  localparam int EPRE = 3;
  localparam int URG  = 3;
  localparam int OVD  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0, sleepReq = 1'b0, sleepExit = 1'b0, burstOnExit = 1'b0;
  logic refReq, selfCmd, accessOk, urgent;
  logic [4:0] backlog;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refresh_sched #(
    .WAKE_WAIT(WW), .WAKE_COUNT(WC), .ROWS(NR), .SLOT_CYCLES(SL), .SELF_MIN(SMIN),
    .EXIT_PRE(EPRE), .URGENT_LEVEL(URG), .OVERDUE_LIMIT(OVD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .sleepReq(sleepReq),
    .sleepExit(sleepExit), .burstOnExit(burstOnExit), .refReq(refReq),
    .selfCmd(selfCmd), .accessOk(accessOk), .urgent(urgent), .backlog(backlog)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  // grant n owed slots one per edge, then one extra grant on the edge that opens access
  task automatic drain(input int n);
    refGrant = 1'b1;
    for (int k = 1; k <= n; k++) begin
      step();
      chk("R3 backlog per grant", int'(backlog), n - k);
      chk("R4 access held", int'(accessOk), 0);
    end
    step();
    chk("R3 idle grant ignored", int'(backlog), 0);
    chk("R4 access opens", int'(accessOk), 1);
    refGrant = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 refReq", int'(refReq), 0);
    chk("R1 accessOk", int'(accessOk), 0);
    chk("R1 selfCmd", int'(selfCmd), 0);
    chk("R1 urgent", int'(urgent), 0);
    chk("R1 backlog", int'(backlog), 0);
    rstN = 1'b1;

    for (int i = 1; i <= WW; i++) begin
      step();
      chk("R2 wake wait", int'(refReq), (i == WW) ? 1 : 0);
    end
    chk("R2 wake count", int'(backlog), WC);
    drain(WC);

    for (int j = 1; j <= OVD * SL; j++) begin
      step();
      chk("R5 slot rate", int'(backlog), j / SL);
      chk("R6 urgent", int'(urgent), ((j / SL) > URG) ? 1 : 0);
    end
    step();
    chk("R7 overdue reload", int'(backlog), WC);
    chk("R7 access dropped", int'(accessOk), 0);
    drain(WC);

    repeat (2 * SL) step();
    chk("R5 two slots", int'(backlog), 2);
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    chk("R3 single grant", int'(backlog), 1);
    repeat (SL - 2) step();
    chk("R5 before tick", int'(backlog), 1);
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    chk("R5 tick with grant", int'(backlog), 1);

    refGrant = 1'b1;
    sleepReq = 1'b1;
    step();
    refGrant = 1'b0;
    chk("R8 no sleep while owed", int'(selfCmd), 0);
    chk("R3 last grant", int'(backlog), 0);
    step();
    chk("R8 sleep entered", int'(selfCmd), 1);
    chk("R8 access off", int'(accessOk), 0);
    sleepReq = 1'b0;
    sleepExit = 1'b1;
    for (int k = 1; k <= SMIN; k++) begin
      step();
      chk("R9 self minimum", int'(selfCmd), (k < SMIN) ? 1 : 0);
      chk("R9 no slots", int'(backlog), 0);
    end
    for (int k = 1; k <= EPRE; k++) begin
      step();
      chk("R10 gap access", int'(accessOk), (k == EPRE) ? 1 : 0);
      chk("R10 gap request", int'(refReq), 0);
    end
    sleepExit = 1'b0;
    chk("R11 plain resume", int'(backlog), 0);

    burstOnExit = 1'b1;
    sleepReq = 1'b1;
    step();
    chk("R8 second entry", int'(selfCmd), 1);
    sleepReq = 1'b0;
    sleepExit = 1'b1;
    repeat (SMIN) step();
    chk("R9 second exit", int'(selfCmd), 0);
    repeat (EPRE) step();
    sleepExit = 1'b0;
    chk("R11 burst load", int'(backlog), NR);
    chk("R11 burst request", int'(refReq), 1);
    chk("R11 access held", int'(accessOk), 0);
    drain(NR);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule